// File: doc/BRIEF.md
# Burst-of-Four Dual-Port DDR Static Memory

This block is a synthesizable model of a static memory with a separate read port and a separate write port, both of which can start a transfer on the same cycle. Data cross the bus at double data rate. The block runs on a beat clock that has one rising edge per half period of the input clock pair. Even beats, counted from the end of reset, stand for the rising edge of the true input clock. Odd beats stand for the rising edge of its complement. Every transfer is a burst of four bus-width beats, and the storage word is four beats wide. The address therefore selects a whole four-beat word.

A write command brings its first data beat with it, and three more beats follow on the next three beat edges. Each beat carries its own per-lane byte enables. A deserializer gathers the beats and commits all four to the array on the edge of the last beat. A read command fetches one wide word, and a serializer then presents that word one beat at a time with a valid strobe. The read fetch is held back until any write accepted on the same edge or earlier has been committed. A read therefore always returns the newest data for its address.

Top module: `qdr_burst_sram`

## Requirements
- R1: While reset is high, and after reset is released, `rd_valid` is 0 and `rd_data` is 0 until a read burst is delivered.
- R2: `wr_req` and `rd_req` are sampled only on even beats. Beat 0 is the first clock edge with reset low. A request that is present only on an odd beat is ignored.
- R3: When a write is accepted on beat E, the `wr_data` values at beats E, E+1, E+2 and E+3 become bus beats 0, 1, 2 and 3 of the word at `wr_addr`.
- R4: Lane j of a beat is bits [9j+8:9j] of `wr_data`. Bit j of `wr_be` (1 = write) is sampled with that same beat. A lane whose enable is 0 keeps its stored value.
- R5: After a read is accepted on beat E, `rd_valid` is high for exactly the four beat edges E+5 to E+8. On those edges `rd_data` carries bus beats 0, 1, 2 and 3 of the word, in that order.
- R6: A command of either kind that arrives while a burst of the same kind is still in progress (two beats after its start) is ignored.
- R7: A read returns the data of every write accepted on the same beat or earlier, including a write to the same address on the same beat. It does not see writes accepted later.
- R8: A read and a write accepted on the same beat both complete.
- R9: Reads accepted on consecutive even-beat pairs (every four beats) produce an unbroken stream of valid beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock, one edge per data beat |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | Write command, sampled on even beats |
| wr_addr | input | ADDR_W (6) | Word address of the write |
| wr_data | input | LANE_W*LANES (36) | Write data beat |
| wr_be | input | LANES (4) | Per-lane write enables for this beat |
| rd_req | input | 1 | Read command, sampled on even beats |
| rd_addr | input | ADDR_W (6) | Word address of the read |
| rd_data | output | LANE_W*LANES (36) | Read data beat |
| rd_valid | output | 1 | High when rd_data carries a beat |

## Verification
The bench builds the block with its defaults: four 9-bit lanes and six address bits, which gives 64 words. With only 64 words, every word can be filled and read back in a few hundred beats. Four lanes per beat give sixteen independent enables per burst, so per-beat masks with different lane patterns on each beat can be tried. Short bursts make it cheap to place a request on the odd beat, two beats into a busy burst, or on the same beat as a write. This covers the cases where write and read are accepted together, where the read comes before the write, and where the read follows the write.

// File: rtl/qsr_pkg.sv
package qsr_pkg;
  localparam int BURST = 4;
  localparam int BEAT_W = $clog2(BURST);
  typedef logic [BEAT_W-1:0] beat_idx_t;
  localparam beat_idx_t LAST_BEAT = beat_idx_t'(BURST - 1);
endpackage

// File: rtl/qsr_wr_deser.sv
module qsr_wr_deser
  import qsr_pkg::*;
#(
  parameter int DW     = 36,
  parameter int NBE    = 4,
  parameter int ADDR_W = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  acc,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DW-1:0]         data,
  input  logic [NBE-1:0]        be,
  output logic                  busy,
  output logic                  commit,
  output logic [ADDR_W-1:0]     c_addr,
  output logic [BURST*DW-1:0]   c_data,
  output logic [BURST*NBE-1:0]  c_mask
);
  logic [BURST-2:0][DW-1:0]  dbuf;
  logic [BURST-2:0][NBE-1:0] mbuf;
  logic [ADDR_W-1:0]         addr_q;
  beat_idx_t                 cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (acc) begin
      busy    <= 1'b1;
      cnt     <= beat_idx_t'(1);
      addr_q  <= addr;
      dbuf[0] <= data;
      mbuf[0] <= be;
    end else if (busy) begin
      if (cnt == LAST_BEAT) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        dbuf[cnt] <= data;
        mbuf[cnt] <= be;
        cnt       <= cnt + beat_idx_t'(1);
      end
    end
  end

  // last beat goes straight to the array together with the held ones
  assign commit = busy && (cnt == LAST_BEAT);
  assign c_addr = addr_q;
  assign c_data = {data, dbuf};
  assign c_mask = {be, mbuf};

  AST_COMMIT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    commit |-> $past(acc, 3)); // R3
endmodule

// File: rtl/qsr_array.sv
module qsr_array #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int NLANE  = 16
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [ADDR_W-1:0]        waddr,
  input  logic [NLANE*LANE_W-1:0]  wdata,
  input  logic [NLANE-1:0]         wmask,
  input  logic                     re,
  input  logic [ADDR_W-1:0]        raddr,
  output logic [NLANE*LANE_W-1:0]  rdata
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WORD_W = NLANE * LANE_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int l = 0; l < NLANE; l++) begin
        if (wmask[l]) mem[waddr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/qsr_rd_ser.sv
module qsr_rd_ser
  import qsr_pkg::*;
#(
  parameter int DW     = 36,
  parameter int ADDR_W = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 acc,
  input  logic [ADDR_W-1:0]    addr,
  output logic                 busy,
  output logic                 fetch,
  output logic [ADDR_W-1:0]    f_addr,
  input  logic [BURST*DW-1:0]  word,
  output logic [DW-1:0]        rd_data,
  output logic                 rd_valid
);
  beat_idx_t         rcnt, obeat;
  logic [ADDR_W-1:0] addr_q;
  logic              fpend, oact;

  // hold the fetch back one full burst so a write of the same beat lands first
  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      rcnt  <= '0;
      fpend <= 1'b0;
    end else begin
      fpend <= 1'b0;
      if (acc) begin
        busy   <= 1'b1;
        rcnt   <= beat_idx_t'(1);
        addr_q <= addr;
      end else if (busy) begin
        if (rcnt == LAST_BEAT) begin
          busy   <= 1'b0;
          rcnt   <= '0;
          fpend  <= 1'b1;
          f_addr <= addr_q;
        end else begin
          rcnt <= rcnt + beat_idx_t'(1);
        end
      end
    end
  end

  assign fetch = fpend;

  always_ff @(posedge clk) begin
    if (rst) begin
      oact     <= 1'b0;
      obeat    <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= oact;
      if (oact) begin
        rd_data <= word[obeat*DW +: DW];
        obeat   <= obeat + beat_idx_t'(1);
        if (obeat == LAST_BEAT) oact <= 1'b0;
      end
      if (fpend) begin
        oact  <= 1'b1;
        obeat <= '0;
      end
    end
  end

  AST_FETCH_LATENCY: assert property (@(posedge clk) disable iff (rst)
    fetch |-> $past(acc, 4)); // R7
  AST_FETCH_THEN_VALID: assert property (@(posedge clk) disable iff (rst)
    fetch |=> ##1 rd_valid); // R5
  AST_VALID_RUN: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_valid) |-> $past(rd_valid, 4)); // R5
endmodule

// File: rtl/qdr_burst_sram.sv
module qdr_burst_sram
  import qsr_pkg::*;
#(
  parameter int LANE_W = 9,
  parameter int LANES  = 4,
  parameter int ADDR_W = 6
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_req,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [LANE_W*LANES-1:0]   wr_data,
  input  logic [LANES-1:0]          wr_be,
  input  logic                      rd_req,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [LANE_W*LANES-1:0]   rd_data,
  output logic                      rd_valid
);
  localparam int DW     = LANE_W * LANES;
  localparam int WORD_W = BURST * DW;

  logic                  ph;
  logic                  wr_acc, rd_acc, wbusy, rbusy;
  logic                  commit, fetch;
  logic [ADDR_W-1:0]     c_addr, f_addr;
  logic [WORD_W-1:0]     c_data, rword;
  logic [BURST*LANES-1:0] c_mask;

  // ph == 0 marks the beat of the true input clock's rising edge
  always_ff @(posedge clk) begin
    if (rst) ph <= 1'b0;
    else     ph <= ~ph;
  end

  assign wr_acc = wr_req && !ph && !wbusy;
  assign rd_acc = rd_req && !ph && !rbusy;

  qsr_wr_deser #(.DW(DW), .NBE(LANES), .ADDR_W(ADDR_W)) u_wr (
    .clk(clk), .rst(rst), .acc(wr_acc), .addr(wr_addr), .data(wr_data),
    .be(wr_be), .busy(wbusy), .commit(commit), .c_addr(c_addr),
    .c_data(c_data), .c_mask(c_mask)
  );

  qsr_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .NLANE(BURST*LANES)) u_mem (
    .clk(clk), .we(commit), .waddr(c_addr), .wdata(c_data), .wmask(c_mask),
    .re(fetch), .raddr(f_addr), .rdata(rword)
  );

  qsr_rd_ser #(.DW(DW), .ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst(rst), .acc(rd_acc), .addr(rd_addr), .busy(rbusy),
    .fetch(fetch), .f_addr(f_addr), .word(rword),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  AST_WR_SPACING: assert property (@(posedge clk) disable iff (rst)
    wr_acc |-> !$past(wr_acc) && !$past(wr_acc, 2)); // R6
  AST_RD_SPACING: assert property (@(posedge clk) disable iff (rst)
    rd_acc |-> !$past(rd_acc) && !$past(rd_acc, 2)); // R6
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> !rd_valid); // R1
endmodule

// File: tb/qdr_burst_sram_bench.sv
module qdr_burst_sram_bench;
  localparam int CLK_P  = 10;
  localparam int LANE_W = 9;
  localparam int LANES  = 4;
  localparam int ADDR_W = 6;
  localparam int DW     = LANE_W * LANES;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_req = 1'b0, rd_req = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [LANES-1:0] wr_be = '0;
  logic [DW-1:0] rd_data;
  logic rd_valid;

  always #(CLK_P/2) clk = ~clk;

  qdr_burst_sram #(.LANE_W(LANE_W), .LANES(LANES), .ADDR_W(ADDR_W)) u_qdr_burst_sram (
    .clk(clk), .rst(rst), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_be(wr_be), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  int checks = 0, fails = 0;
  string tag = "R1 reset";

  // behavioural reference
  logic [4*DW-1:0] ref_mem [DEPTH];
  logic [DW-1:0]   exp_d [int];
  int nedge = 0, wfree = 0, rfree = 0, wstart = 0, rstart = 0;
  bit wact = 0, rpend = 0;
  int wa = 0, ra = 0;

  always @(posedge clk) begin
    if (rst) begin
      nedge = 0; wfree = 0; rfree = 0; wact = 0; rpend = 0;
    end else begin
      automatic int e = nedge;
      if (rpend && e == rstart + 4) begin
        for (int j = 0; j < 4; j++) exp_d[e + 1 + j] = ref_mem[ra][j*DW +: DW];
        rpend = 0;
      end
      if (e % 2 == 0 && wr_req && e >= wfree) begin
        wact = 1; wstart = e; wfree = e + 4; wa = int'(wr_addr);
      end
      if (wact) begin
        automatic int k = e - wstart;
        for (int l = 0; l < LANES; l++)
          if (wr_be[l]) ref_mem[wa][k*DW + l*LANE_W +: LANE_W] = wr_data[l*LANE_W +: LANE_W];
        if (k == 3) wact = 0;
      end
      if (e % 2 == 0 && rd_req && e >= rfree) begin
        rpend = 1; rstart = e; rfree = e + 4; ra = int'(rd_addr);
      end
      nedge = nedge + 1;
    end
  end

  // compare on every beat
  always @(negedge clk) begin
    if (!rst && nedge > 0) begin
      automatic int idx = nedge - 1;
      automatic bit ev = exp_d.exists(idx);
      checks++;
      if (rd_valid !== ev || (ev && rd_data !== exp_d[idx])) begin
        fails++;
        $display("FAIL %s: edge %0d valid=%0b data=%h expected valid=%0b data=%h",
                 tag, idx, rd_valid, rd_data, ev, ev ? exp_d[idx] : '0);
      end
    end
  end

  function automatic logic [DW-1:0] patt(int a, int b, int s);
    return DW'(a * 32'h01F3 + b * 32'h0B5 + s * 32'h2717 + 32'h5A5);
  endfunction

  task automatic align_even();
    while (nedge % 2 != 0) @(negedge clk);
  endtask

  task automatic burst(input bit do_w, input int wad, input int seed,
                       input logic [4*LANES-1:0] mask, input bit do_r, input int rad);
    align_even();
    for (int k = 0; k < 4; k++) begin
      wr_req  = do_w && (k == 0);
      rd_req  = do_r && (k == 0);
      wr_addr = ADDR_W'(wad);
      rd_addr = ADDR_W'(rad);
      wr_data = patt(wad, k, seed);
      wr_be   = mask[k*LANES +: LANES];
      @(negedge clk);
    end
    wr_req = 0; rd_req = 0;
  endtask

  task automatic drain();
    repeat (12) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    checks++;
    if (rd_valid !== 1'b0 || rd_data !== '0) begin
      fails++;
      $display("FAIL R1: valid=%0b data=%h expected valid=0 data=0", rd_valid, rd_data);
    end
    rst = 0;
    @(negedge clk);

    tag = "R3 full writes";
    for (int a = 0; a < DEPTH; a++) burst(1, a, 1, '1, 0, 0);

    tag = "R9 back-to-back reads (R5)";
    for (int a = 0; a < DEPTH; a++) burst(0, 0, 0, '0, 1, a);
    drain();

    tag = "R4 per-beat lane masks";
    burst(1, 3, 7, 16'b1000_0100_0010_0001, 0, 0);
    burst(1, 9, 8, 16'b0111_1011_1101_1110, 0, 0);
    burst(1, 12, 9, 16'b0000_1111_0000_0101, 0, 0);
    burst(0, 0, 0, '0, 1, 3);
    burst(0, 0, 0, '0, 1, 9);
    burst(0, 0, 0, '0, 1, 12);
    drain();

    tag = "R2 odd-beat requests";
    align_even();
    @(negedge clk);
    wr_req = 1; wr_addr = 5; wr_data = '1; wr_be = '1;
    rd_req = 1; rd_addr = 5;
    @(negedge clk);
    wr_req = 0; rd_req = 0;
    @(negedge clk);
    burst(0, 0, 0, '0, 1, 5);
    drain();

    tag = "R6 requests during busy burst";
    align_even();
    wr_req = 1; wr_addr = 20; rd_req = 1; rd_addr = 21; wr_be = '1; wr_data = patt(20, 0, 3);
    @(negedge clk); wr_req = 0; rd_req = 0; wr_data = patt(20, 1, 3);
    @(negedge clk); wr_req = 1; wr_addr = 22; rd_req = 1; rd_addr = 23; wr_data = patt(20, 2, 3);
    @(negedge clk); wr_req = 0; rd_req = 0; wr_data = patt(20, 3, 3);
    @(negedge clk);
    drain();
    burst(0, 0, 0, '0, 1, 22);
    burst(0, 0, 0, '0, 1, 20);
    drain();

    tag = "R7 R8 same-beat read and write";
    burst(1, 30, 11, '1, 1, 30);
    drain();
    tag = "R7 read before write";
    burst(0, 0, 0, '0, 1, 31);
    burst(1, 31, 12, 16'h0F0F, 0, 0);
    drain();
    tag = "R7 read after partial write";
    burst(1, 32, 13, 16'hA5C3, 0, 0);
    burst(1, 33, 14, '1, 1, 32);
    burst(0, 0, 0, '0, 1, 33);
    burst(0, 0, 0, '0, 1, 31);
    drain();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule